// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single read or write transactions on the two-wire station management bus of an Ethernet PHY. Each transaction touches one 16-bit PHY register. The host presents one request: a read/write flag, a 5-bit PHY address, a 5-bit register address and, for writes, a data word. The block accepts it when idle. It then serialises a complete management frame on the clock pin and the bidirectional data pin, and finishes with a one-cycle completion pulse. A read returns its word in a holding register that is valid in that same cycle.

The pin side works like a software bit-bang word, with four separate signals: the management clock, an output enable that means "drive" when high, the outgoing data bit and the incoming data bit. The board supplies the tri-state buffer. Every clock phase lasts a run-time number of system clocks, which sets the management clock rate.

Driven bits take three equal phases: clock low, clock high, clock low. The data bit stays constant through all three. On a read, the bus is released for one whole low-high-low period, and the 16 reply bits are then taken in while the clock is high. On a write, the turnaround is driven by the master, and the frame closes with a single released phase.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Every frame begins with 32 driven ones followed by the start field 0 then 1.
- R2: After the start field come the 2-bit opcode (1,0 for read; 0,1 for write), then the 5-bit PHY address, then the 5-bit register address.
- R3: Every field, the 16-bit data included, goes out or comes in most significant bit first; the first reply bit of a read lands in rd_data[15].
- R4: Each driven bit occupies three phases with mdio_oe high: mdc low, high, low; mdio_out does not change within those three phases.
- R5: On a read, the register address is followed by exactly one released period (mdio_oe low, mdc low, high, low). Then come 16 released reply bits, each an mdc-high phase followed by an mdc-low phase. mdio_in is sampled at the end of the high phase. A read has 46 driven bits and 35 phases with mdio_oe low.
- R6: On a write, the register address is followed by a driven turnaround of 1 then 0 and then the 16 data bits, for 64 driven bits in all.
- R7: A write ends with exactly one phase with mdio_oe low and mdc low, after which done is raised.
- R8: Every phase lasts phase_len system clocks, and a value of 0 acts as 1. With L the effective length, done rises 193*L cycles after the accepting edge for a write and 173*L for a read.
- R9: busy is high from the cycle after a request is accepted until done. done lasts one cycle, and busy is low in that cycle.
- R10: A request presented while busy is ignored: the frame in flight and its timing are unaffected and no second transaction follows.
- R11: rd_data changes only when a read completes and is valid in the done cycle; a write leaves it unchanged.
- R12: When idle, mdc, mdio_oe and mdio_out are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_len | input | DIV_W | System clocks per management-clock phase (0 acts as 1) |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last read word |
| mdc | output | 1 | Management clock |
| mdio_oe | output | 1 | Data pin drive enable (1 = drive) |
| mdio_out | output | 1 | Data pin outgoing value |
| mdio_in | input | 1 | Data pin incoming value |

## Verification
The assertions assume phase_len does not change while a frame is running. The block latches it at acceptance, and the stimulus only changes it between transactions. They also assume a request strobe can arrive at any time. The bench deliberately raises one mid-frame, with every field inverted, to exercise the ignore rule. The PHY model in the bench drives mdio_in only in released phases and changes it on the rising edge of mdc, so each reply bit is stable by the end of the high phase when the block samples it.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int ADDR_W  = 5;
  localparam int WORD_W  = 16;
  localparam int FRAME_W = 64;
  localparam int CNT_W   = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_TURN,
    ST_RECV,
    ST_PARK
  } mgmt_state_e;

  // Left-aligned outgoing bit pattern; shifted out from bit 63.
  function automatic logic [FRAME_W-1:0] frame_bits(
    input logic              wr,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] rg,
    input logic [WORD_W-1:0] wd
  );
    logic [1:0] opc;
    logic [17:0] tail;
    opc  = wr ? 2'b01 : 2'b10;
    tail = wr ? {2'b10, wd} : 18'd0;
    return {32'hFFFF_FFFF, 2'b01, opc, phy, rg, tail};
  endfunction

  // Number of driven bits in a frame.
  function automatic logic [CNT_W-1:0] frame_len(input logic wr);
    return wr ? CNT_W'(64) : CNT_W'(46);
  endfunction

endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         stop,
  input  logic [W-1:0] len,
  output logic         tick
);
  logic [W-1:0] len_q;
  logic [W-1:0] cnt;
  logic         run;
  logic [W-1:0] eff;

  assign eff  = (len == '0) ? W'(1) : len;
  assign tick = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      len_q <= W'(1);
      cnt   <= '0;
    end else if (start) begin
      run   <= 1'b1;
      len_q <= eff;
      cnt   <= eff - W'(1);
    end else if (stop) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= tick ? (len_q - W'(1)) : (cnt - W'(1));
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < len_q)); // R8

endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[W-2:0], din};
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  phase_len,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [4:0]        req_phy,
  input  logic [4:0]        req_reg,
  input  logic [15:0]       req_wdata,
  output logic              busy,
  output logic              done,
  output logic [15:0]       rd_data,
  output logic              mdc,
  output logic              mdio_oe,
  output logic              mdio_out,
  input  logic              mdio_in
);
  mgmt_state_e          state;
  logic [1:0]           ph;
  logic [CNT_W-1:0]     bit_left;
  logic [FRAME_W-1:0]   sr;
  logic                 is_wr;
  logic [WORD_W-1:0]    rx_word;

  // Named internal events
  logic tick;
  logic accept;
  logic finish;
  logic sample_en;
  logic last_bit;

  assign busy      = (state != ST_IDLE);
  assign accept    = req_valid && !busy;
  assign last_bit  = (bit_left == '0);
  assign finish    = tick && (((state == ST_RECV) && (ph == 2'd1) && last_bit)
                              || (state == ST_PARK));
  assign sample_en = tick && (state == ST_RECV) && (ph == 2'd0);

  mdio_phase_timer #(.W(DIV_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .stop  (finish),
    .len   (phase_len),
    .tick  (tick)
  );

  mdio_rx_capture #(.W(WORD_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (sample_en),
    .din      (mdio_in),
    .word     (rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ph       <= 2'd0;
      bit_left <= '0;
      sr       <= '0;
      is_wr    <= 1'b0;
      rd_data  <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        state    <= ST_SEND;
        ph       <= 2'd0;
        bit_left <= frame_len(req_write) - CNT_W'(1);
        sr       <= frame_bits(req_write, req_phy, req_reg, req_wdata);
        is_wr    <= req_write;
      end else if (tick) begin
        case (state)
          ST_SEND: begin
            if (ph != 2'd2) ph <= ph + 2'd1;
            else begin
              ph <= 2'd0;
              if (last_bit) state <= is_wr ? ST_PARK : ST_TURN;
              else begin
                bit_left <= bit_left - CNT_W'(1);
                sr       <= {sr[FRAME_W-2:0], 1'b0};
              end
            end
          end
          ST_TURN: begin
            if (ph != 2'd2) ph <= ph + 2'd1;
            else begin
              ph       <= 2'd0;
              state    <= ST_RECV;
              bit_left <= CNT_W'(WORD_W - 1);
            end
          end
          ST_RECV: begin
            if (ph == 2'd0) ph <= 2'd1;
            else begin
              ph <= 2'd0;
              if (last_bit) begin
                state   <= ST_IDLE;
                done    <= 1'b1;
                rd_data <= rx_word;
              end else begin
                bit_left <= bit_left - CNT_W'(1);
              end
            end
          end
          ST_PARK: begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // Pin view: driven bits and turnaround pulse in the middle phase,
  // reply bits pulse in their first phase.
  always_comb begin
    case (state)
      ST_SEND, ST_TURN: mdc = (ph == 2'd1);
      ST_RECV:          mdc = (ph == 2'd0);
      default:          mdc = 1'b0;
    endcase
  end
  assign mdio_oe  = (state == ST_SEND);
  assign mdio_out = (state == ST_SEND) && sr[FRAME_W-1];

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe && !mdio_out)); // R12
  AST_BIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && ph != 2'd0) |-> $stable(mdio_out)); // R4
  AST_TURN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TURN) |-> !mdio_oe); // R5
  AST_PARK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PARK) |-> (!mdio_oe && !mdc)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(is_wr) && $stable(bit_left[CNT_W-1])); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> done); // R11

endmodule

// File: tb/mdio_mgmt_master_test.sv
`timescale 1ns/1ps
module mdio_mgmt_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  phase_len = 8'd1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, mdc, mdio_oe, mdio_out;
  logic [15:0] rd_data;
  logic        mdio_in = 1'b0;

  int checks = 0;
  int fails  = 0;
  logic [15:0] last_rd = '0;

  always #10 clk = ~clk;

  mdio_mgmt_master uut (
    .clk(clk), .rst_n(rst_n), .phase_len(phase_len),
    .req_valid(req_valid), .req_write(req_write), .req_phy(req_phy),
    .req_reg(req_reg), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .mdc(mdc), .mdio_oe(mdio_oe), .mdio_out(mdio_out),
    .mdio_in(mdio_in)
  );

  // {write, phy, reg, data, len}
  localparam int NV = 6;
  localparam logic [34:0] VEC [NV] = '{
    {1'b1, 5'h1F, 5'h00, 16'h8000, 8'd1},
    {1'b0, 5'h01, 5'h1F, 16'hA5C3, 8'd1},
    {1'b1, 5'h15, 5'h0A, 16'h1234, 8'd2},
    {1'b0, 5'h0A, 5'h15, 16'h0001, 8'd3},
    {1'b0, 5'h00, 5'h01, 16'hFFFE, 8'd0},
    {1'b1, 5'h1E, 5'h11, 16'h0000, 8'd0}
  };

  task automatic check(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input logic wr, input logic [4:0] phy,
                         input logic [4:0] rg, input logic [15:0] data,
                         input logic [7:0] len, input int inject);
    logic [63:0] tx_bits = '0;
    logic [63:0] exp_full;
    logic [63:0] exp_r;
    int tx_n = 0, rel = 0, ridx = 0, k = 0, lenf, exp_k, exp_n, exp_rel;
    logic prev_mdc = 1'b0;
    lenf     = (len == 0) ? 1 : int'(len);
    exp_n    = wr ? 64 : 46;
    exp_k    = (wr ? 193 : 173) * lenf;
    exp_rel  = wr ? lenf : 35 * lenf;
    exp_full = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
                (wr ? {2'b10, data} : 18'd0)};
    exp_r    = exp_full >> (64 - exp_n);
    phase_len = len;
    req_write = wr; req_phy = phy; req_reg = rg; req_wdata = data;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy === 1'b1, "R9 busy after accept", {63'd0, busy}, 64'd1);
    while (k < 20000) begin
      if (mdc && !prev_mdc) begin
        if (mdio_oe) begin
          tx_bits = {tx_bits[62:0], mdio_out};
          tx_n++;
        end else begin
          ridx++;
          if (ridx >= 2 && ridx <= 17) mdio_in = data[17 - ridx];
        end
      end
      prev_mdc = mdc;
      if (busy && !mdio_oe) rel++;
      if (done) break;
      if (k == inject) begin
        req_valid = 1'b1; req_write = ~wr; req_phy = ~phy;
        req_reg = ~rg; req_wdata = ~data;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    req_valid = 1'b0;
    check(k == exp_k, "R8 done cycle", 64'(k), 64'(exp_k));
    check(tx_n == exp_n, "R2 R6 driven bit count", 64'(tx_n), 64'(exp_n));
    check(tx_bits == exp_r, "R1 R3 driven pattern", tx_bits, exp_r);
    check(rel == exp_rel, "R5 R7 released phases", 64'(rel), 64'(exp_rel));
    if (!wr) last_rd = data;
    check(rd_data == last_rd, "R3 R11 rd_data at done", {48'd0, rd_data},
          {48'd0, last_rd});
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R9 R10 single done, no second txn",
          {62'd0, done, busy}, 64'd0);
    check(!mdc && !mdio_oe && !mdio_out, "R12 idle pins",
          {61'd0, mdc, mdio_oe, mdio_out}, 64'd0);
    mdio_in = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 R9 R11: reset state
    check(!busy && !done && !mdc && !mdio_oe && !mdio_out && rd_data == 16'h0,
          "R12 reset state", {43'd0, rd_data, busy, done, mdc, mdio_oe, mdio_out}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // Request held while idle does nothing until strobed (R9 reset quiet)
    check(busy == 1'b0, "R9 idle after reset", {63'd0, busy}, 64'd0);
    for (int i = 0; i < NV; i++) begin
      run_txn(VEC[i][34], VEC[i][33:29], VEC[i][28:24], VEC[i][23:8],
              VEC[i][7:0], -1);
    end
    // R10: inverted request mid-write and mid-read
    run_txn(1'b1, 5'h05, 5'h1B, 16'hC33C, 8'd1, 20);
    run_txn(1'b0, 5'h12, 5'h07, 16'h5AA5, 8'd2, 150);
    // R11: write after read keeps the read word
    run_txn(1'b1, 5'h03, 5'h04, 16'hFFFF, 8'd1, -1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule